// File: doc/BRIEF.md
# Camera Sensor Control Register Target

This block is the control side of a camera sensor. It sits on a two-wire, I2C-compatible serial bus as a target and gives a host access to a small byte-addressed register file. The host addresses the block with a 7-bit device address. It can then send a 16-bit register index, high byte first, followed by data bytes to write. It can also issue a repeated START and read data back. A register pointer inside the block persists between transactions. Because of this, a read that skips the index phase continues from wherever the last transfer stopped. The pointer advances by one after every data byte, in both directions.

One register in the file is wider than a byte. Its width is a whole number of bytes and it is stored big-endian, so the lowest index holds the most significant byte. Host writes to it collect in a shadow buffer, and internal logic only ever sees the complete value. The buffer is committed when the final byte of the register arrives, or at STOP if the host wrote only part of it. The block's own logic may load a new value into the wide register at any time. When a host read addresses the first byte of the wide register, the whole register is snapshotted, so the bytes returned in that read belong to one value.

The serial inputs are synchronized to the system clock. The block drives the data line only by pulling it low, through an output-enable pin.

Top module: `cam_cci_target`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0), the wide register reads 0, and every register in the file returns 0x00.
- R2: An address byte whose upper seven bits differ from the device address (default 0x36) gets no acknowledge. Every byte that follows it, up to the next START, is ignored, and no register changes.
- R3: A write transaction carries the device address with R/W bit 0, two index bytes (high byte first) and data bytes. The block acknowledges the matching address, both index bytes and each data byte by holding the data line low during the ninth clock. A single write of one data byte updates exactly the addressed register.
- R4: A read transaction uses the device address with R/W bit 1. In a random-location read, the host first writes the index, then issues a repeated START and reads. The byte returned is the one stored at that index, sent most significant bit first. The block changes the data line only while the serial clock is low.
- R5: In a sequential write, the first data byte goes to the given index and each later data byte goes to the next index up.
- R6: In a sequential read, each byte comes from the index after the previous one. When the host does not acknowledge a byte, the transfer ends and the block releases the data line.
- R7: A current-location read returns data starting at the pointer left by the last transfer, even after a STOP. The pointer is one past the last byte written or read.
- R8: Bytes written to the wide register (default indices 8 to 11, index 8 most significant) do not change `wide_q` until the byte at its last index is written. At that point the whole value changes in one cycle.
- R9: If a transaction ends with STOP after writing only some bytes of the wide register, those bytes are committed together at the STOP. The bytes that were not written keep their previous values.
- R10: Reading the wide register's first byte captures the whole register. Later bytes of that read come from the capture, even if `hw_load` changes `wide_q` in the meantime.
- R11: Indices at or above the register-file size (default 16) read as 0x00 and ignore writes. Such writes are still acknowledged, and no register inside the file changes.
- R12: A pulse on `hw_load` copies `hw_data` into `wide_q` on the next clock edge. A host commit in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| hw_load | input | 1 | Internal update strobe for the wide register |
| hw_data | input | 8*WIDE_BYTES | Value loaded by `hw_load` |
| wide_q | output | 8*WIDE_BYTES | Committed wide-register value seen by internal logic |

## Verification
The hardest case to produce from the pins is an internal update that lands in the middle of a multi-byte host read of the wide register. The race only exists while the bus is between bytes of one read. To create it, the stimulus reads the first byte, pulses `hw_load` with a very different value, and then reads the remaining bytes. It then starts a fresh read to show that the new value did arrive. The partial-write commit at STOP is reached in a similar way. A transaction writes a middle byte of the wide register, `wide_q` is sampled before the STOP and again after it, and so the commit point can be seen from outside.

// File: rtl/cam_cci_pkg.sv
package cam_cci_pkg;
  localparam int PTR_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_TX,
    ST_TX,
    ST_ACK_RX
  } link_state_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_IDX_HI,
    PH_IDX_LO,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/cam_cci_line_sync.sv
module cam_cci_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic scl_m, scl_q, scl_d;
  logic sda_m, sda_q, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_q <= 1'b1; scl_d <= 1'b1;
      sda_m <= 1'b1; sda_q <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_q <= scl_m; scl_d <= scl_q;
      sda_m <= sda_i; sda_q <= sda_m; sda_d <= sda_q;
    end
  end

  assign scl_s    = scl_q;
  assign sda_s    = sda_q;
  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  assign start_p  = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_p   = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/cam_cci_link.sv
module cam_cci_link
  import cam_cci_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             fetch
);
  link_state_e      state_q, state_d;
  phase_e           phase_q, phase_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       hi_q, hi_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             rw_q, rw_d;
  logic             oe_q, oe_d;
  logic             hack_q, hack_d;

  always_comb begin
    state_d = state_q; phase_d = phase_q; cnt_d = cnt_q; sh_d = sh_q;
    hi_d = hi_q; ptr_d = ptr_q; rw_d = rw_q; oe_d = oe_q; hack_d = hack_q;
    wr_en = 1'b0; fetch = 1'b0;
    if (stop_p) begin
      state_d = ST_IDLE; oe_d = 1'b0;
    end else if (start_p) begin
      state_d = ST_RX; phase_d = PH_DEV; cnt_d = '0; oe_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            cnt_d   = '0;
            state_d = ST_ACK_TX;
            oe_d    = 1'b1;
            unique case (phase_q)
              PH_DEV: begin
                if (sh_q[7:1] == DEV_ADDR) rw_d = sh_q[0];
                else begin state_d = ST_IDLE; oe_d = 1'b0; end
              end
              PH_IDX_HI: hi_d  = sh_q;
              PH_IDX_LO: ptr_d = {hi_q, sh_q};
              PH_DATA: begin
                wr_en = 1'b1;
                ptr_d = ptr_q + 1'b1;
              end
            endcase
          end
        end
        ST_ACK_TX: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (phase_q == PH_DEV && rw_q) begin
              fetch = 1'b1; sh_d = rd_data; ptr_d = ptr_q + 1'b1;
              oe_d = ~rd_data[7]; state_d = ST_TX;
            end else begin
              oe_d = 1'b0; state_d = ST_RX;
              phase_d = (phase_q == PH_DEV)    ? PH_IDX_HI :
                        (phase_q == PH_IDX_HI) ? PH_IDX_LO : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_d = 1'b0; state_d = ST_ACK_RX;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              oe_d  = ~sh_q[6];
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        ST_ACK_RX: begin
          if (scl_rise) hack_d = ~sda_s;
          else if (scl_fall) begin
            cnt_d = '0;
            if (hack_q) begin
              fetch = 1'b1; sh_d = rd_data; ptr_d = ptr_q + 1'b1;
              oe_d = ~rd_data[7]; state_d = ST_TX;
            end else state_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; phase_q <= PH_DEV; cnt_q <= '0; sh_q <= '0;
      hi_q <= '0; ptr_q <= '0; rw_q <= 1'b0; oe_q <= 1'b0; hack_q <= 1'b0;
    end else begin
      state_q <= state_d; phase_q <= phase_d; cnt_q <= cnt_d; sh_q <= sh_d;
      hi_q <= hi_d; ptr_q <= ptr_d; rw_q <= rw_d; oe_q <= oe_d; hack_q <= hack_d;
    end
  end

  assign sda_oe  = oe_q;
  assign ptr     = ptr_q;
  assign wr_data = sh_q;

  // R6
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK_RX && scl_fall && !hack_q && !start_p && !stop_p) |=> !sda_oe);
endmodule

// File: rtl/cam_cci_regs.sv
module cam_cci_regs
  import cam_cci_pkg::*;
#(
  parameter int NUM_BYTES  = 16,
  parameter int WIDE_BASE  = 8,
  parameter int WIDE_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PTR_W-1:0]        addr,
  input  logic                    wr_en,
  input  logic [7:0]              wr_data,
  input  logic                    fetch,
  input  logic                    stop_p,
  input  logic                    hw_load,
  input  logic [8*WIDE_BYTES-1:0] hw_data,
  output logic [7:0]              rd_data,
  output logic [8*WIDE_BYTES-1:0] wide_q
);
  localparam int WIDE_W = 8 * WIDE_BYTES;
  localparam int AW     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int OW     = (WIDE_BYTES > 1) ? $clog2(WIDE_BYTES) : 1;

  logic [8*NUM_BYTES-1:0] mem_q, mem_d;
  logic [WIDE_W-1:0]      shadow_q, shadow_d, snap_q, snap_d, wide_d;
  logic                   pend_q, pend_d;
  logic                   in_range, in_wide, wide_hit, last_hit, commit;
  logic [PTR_W-1:0]       off_full;
  logic [OW-1:0]          off;
  logic [AW-1:0]          idx;

  assign in_range = addr < PTR_W'(NUM_BYTES);
  assign in_wide  = (addr >= PTR_W'(WIDE_BASE)) && (addr < PTR_W'(WIDE_BASE + WIDE_BYTES));
  assign off_full = addr - PTR_W'(WIDE_BASE);
  assign off      = off_full[OW-1:0];
  assign idx      = addr[AW-1:0];
  assign wide_hit = wr_en && in_wide;
  assign last_hit = wide_hit && (off == OW'(WIDE_BYTES - 1));
  assign commit   = last_hit || (stop_p && pend_q);

  always_comb begin
    mem_d = mem_q;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (wr_en && addr == PTR_W'(i) && !(i >= WIDE_BASE && i < WIDE_BASE + WIDE_BYTES))
        mem_d[8*i +: 8] = wr_data;
    end
  end

  for (genvar L = 0; L < WIDE_BYTES; L++) begin : g_lane
    localparam int HI = WIDE_W - 1 - 8 * L;
    assign shadow_d[HI -: 8] = (wide_hit && off == OW'(L)) ? wr_data :
                               (pend_q ? shadow_q[HI -: 8] : wide_q[HI -: 8]);
  end

  always_comb begin
    pend_d = commit ? 1'b0 : (wide_hit ? 1'b1 : pend_q);
    wide_d = commit ? shadow_d : (hw_load ? hw_data : wide_q);
    snap_d = (fetch && in_wide && off == '0) ? wide_q : snap_q;
    if (!in_range)      rd_data = 8'h00;
    else if (in_wide)   rd_data = (off == '0) ? wide_q[WIDE_W-1 -: 8]
                                              : snap_q[WIDE_W - 1 - 8 * int'(off) -: 8];
    else                rd_data = mem_q[8*idx +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0; shadow_q <= '0; snap_q <= '0; wide_q <= '0; pend_q <= 1'b0;
    end else begin
      mem_q <= mem_d; shadow_q <= shadow_d; snap_q <= snap_d;
      wide_q <= wide_d; pend_q <= pend_d;
    end
  end

  // R8
  wide_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wide_q) |-> $past(hw_load || stop_p || wr_en));

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_load && !fetch && in_wide && off != '0) |=> (!$stable(addr) || $stable(rd_data)));
endmodule

// File: rtl/cam_cci_target.sv
module cam_cci_target
  import cam_cci_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h36,
  parameter int         NUM_BYTES  = 16,
  parameter int         WIDE_BASE  = 8,
  parameter int         WIDE_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  input  logic                    hw_load,
  input  logic [8*WIDE_BYTES-1:0] hw_data,
  output logic [8*WIDE_BYTES-1:0] wide_q
);
  logic rst_m, rst_l;
  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic wr_en, fetch;
  logic [7:0] wr_data, rd_data;
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0; rst_l <= 1'b0;
    end else begin
      rst_m <= 1'b1; rst_l <= rst_m;
    end
  end

  cam_cci_line_sync i_sync (
    .clk(clk), .rst_n(rst_l), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  cam_cci_link #(.DEV_ADDR(DEV_ADDR)) i_link (
    .clk(clk), .rst_n(rst_l), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .fetch(fetch)
  );

  cam_cci_regs #(
    .NUM_BYTES(NUM_BYTES), .WIDE_BASE(WIDE_BASE), .WIDE_BYTES(WIDE_BYTES)
  ) i_regs (
    .clk(clk), .rst_n(rst_l), .addr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .fetch(fetch), .stop_p(stop_p), .hw_load(hw_load), .hw_data(hw_data),
    .rd_data(rd_data), .wide_q(wide_q)
  );

  // R4
  sda_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_l)
    !$stable(sda_oe) |-> !scl_s);

  // R5
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_l)
    wr_en |=> !wr_en);
endmodule

// File: tb/test_cam_cci_target.sv
module test_cam_cci_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk, rst_n, scl, sda_h, hw_load, sda_oe;
  logic [31:0] hw_data, wide_q;
  logic sda_line;
  int n_chk, n_bad;

  assign sda_line = sda_h & ~sda_oe;

  cam_cci_target i_cam_cci_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .hw_load(hw_load), .hw_data(hw_data), .wide_q(wide_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_h = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_h = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
    sda_h = 1'b1; wq(Q); scl = 1'b1; wq(Q); ack = ~sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_h = 1'b1; wq(Q); scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl = 1'b0; wq(Q);
    end
    sda_h = last; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q); sda_h = 1'b1;
  endtask

  task automatic open_write(input logic [15:0] idx, input string req);
    logic a;
    bus_start();
    send_byte(8'h6C, a); chk(req, "address ack", a, 1'b1);
    send_byte(idx[15:8], a); chk(req, "index high ack", a, 1'b1);
    send_byte(idx[7:0], a); chk(req, "index low ack", a, 1'b1);
  endtask

  task automatic read_at(input logic [15:0] idx, input int n, output logic [31:0] d);
    logic a;
    logic [7:0] b;
    open_write(idx, "R4");
    bus_start();
    send_byte(8'h6D, a);
    d = '0;
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n-1, b);
      d = {d[23:0], b};
    end
    bus_stop();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "sda released", sda_oe, 1'b0);
    chk("R1", "wide_q", wide_q, 32'h0);
    read_at(16'h0002, 2, d);
    chk("R1", "reset contents", d, 32'h0);
  endtask

  task automatic t_single();
    logic a;
    logic [31:0] d;
    open_write(16'h0003, "R3");
    send_byte(8'hA5, a); chk("R3", "data ack", a, 1'b1);
    bus_stop();
    read_at(16'h0002, 3, d);
    chk("R3", "one register updated", d, 32'h00A500);
    read_at(16'h0003, 1, d);
    chk("R4", "random read", d, 32'hA5);
  endtask

  task automatic t_wrong_dev();
    logic a;
    logic [31:0] d;
    bus_start();
    send_byte(8'h40, a); chk("R2", "no address ack", a, 1'b0);
    send_byte(8'h00, a); send_byte(8'h03, a); send_byte(8'h5A, a);
    bus_stop();
    read_at(16'h0003, 1, d);
    chk("R2", "register untouched", d, 32'hA5);
  endtask

  task automatic t_seq();
    logic a;
    logic [31:0] d;
    logic [7:0] b;
    open_write(16'h0004, "R5");
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); send_byte(8'h77, a);
    chk("R5", "last data ack", a, 1'b1);
    bus_stop();
    read_at(16'h0004, 3, d);
    chk("R6", "sequential read", d, 32'h112233);
    chk("R6", "released after nack", sda_oe, 1'b0);
    bus_start();
    send_byte(8'h6D, a); chk("R7", "read address ack", a, 1'b1);
    recv_byte(1'b1, b);
    bus_stop();
    chk("R7", "current location", b, 8'h77);
  endtask

  task automatic t_wide();
    logic a;
    open_write(16'h0008, "R8");
    send_byte(8'hDE, a); send_byte(8'hAD, a);
    chk("R8", "no partial value", wide_q, 32'h0);
    send_byte(8'hBE, a);
    chk("R8", "still no partial value", wide_q, 32'h0);
    send_byte(8'hEF, a);
    chk("R8", "commit on last byte", wide_q, 32'hDEADBEEF);
    bus_stop();
    open_write(16'h0009, "R9");
    send_byte(8'h55, a);
    chk("R9", "held before stop", wide_q, 32'hDEADBEEF);
    bus_stop();
    chk("R9", "commit at stop", wide_q, 32'hDE55BEEF);
  endtask

  task automatic t_hw_and_coherent();
    logic a;
    logic [31:0] d;
    logic [7:0] b;
    hw_data = 32'h01020304; hw_load = 1'b1; wq(1); hw_load = 1'b0; wq(1);
    chk("R12", "hw load", wide_q, 32'h01020304);
    open_write(16'h0008, "R10");
    bus_start();
    send_byte(8'h6D, a);
    recv_byte(1'b0, b);
    chk("R10", "first wide byte", b, 8'h01);
    hw_data = 32'hA0B0C0D0; hw_load = 1'b1; wq(1); hw_load = 1'b0;
    d = '0;
    for (int k = 0; k < 3; k++) begin
      recv_byte(k == 2, b);
      d = {d[23:0], b};
    end
    bus_stop();
    chk("R10", "snapshot bytes", d, 32'h020304);
    chk("R12", "load landed", wide_q, 32'hA0B0C0D0);
    read_at(16'h0008, 4, d);
    chk("R10", "fresh snapshot", d, 32'hA0B0C0D0);
  endtask

  task automatic t_range();
    logic a;
    logic [31:0] d;
    open_write(16'h0020, "R11");
    send_byte(8'h99, a); chk("R11", "out of range data ack", a, 1'b1);
    bus_stop();
    read_at(16'h0020, 1, d);
    chk("R11", "out of range read", d, 32'h0);
    read_at(16'h0000, 1, d);
    chk("R11", "aliased register untouched", d, 32'h0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    scl = 1'b1; sda_h = 1'b1; hw_load = 1'b0; hw_data = '0;
    rst_n = 1'b0;
    wq(5); rst_n = 1'b1; wq(5);
    t_reset();
    t_single();
    t_wrong_dev();
    t_seq();
    t_wide();
    t_hw_and_coherent();
    t_range();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule